// File: doc/BRIEF.md
# Bus reservation set controller

This block sits on a processor-internal memory bus, between the CPU and the memory or peripheral the CPU reaches. It gives load-reserved and store-conditional word operations their atomic behaviour. Both travel as ordinary bus reads and writes with a reservation-operation flag raised. The controller keeps one reservation entry, made of a valid bit and a word address. It decides whether a store-conditional may reach memory, and it returns the pass or fail result on the normal read-data path.

Ordinary reads, writes, instruction fetches and fence indications pass straight through in the same cycle. A load-reserved also passes through, and it records the word it read. A store-conditional goes downstream only if the reservation is still valid for its word. If the reservation is gone, the controller holds back the downstream strobe and answers the CPU itself one cycle later. A store from the CPU to the reserved word breaks the reservation. So does a write that another bus master reports on a snoop port. The downstream side must answer each strobe no earlier than the following cycle.

Top module: `rsc_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the reservation, and `rsp_ack` is low while reset is held. A store-conditional made after reset, before any load-reserved, fails.
- R2: Requests without both `req_rvso` and `req_we` set are forwarded unchanged in the same cycle: strobe, address, write data, write flag, source, privilege and fence. The fence output follows `req_fence` even when `req_stb` is low. The response data is the memory read data.
- R3: A load-reserved (`req_rvso`=1, `req_we`=0) is forwarded as a read and returns the memory data. It records the word address and makes the reservation valid.
- R4: A store-conditional (`req_rvso`=1, `req_we`=1) succeeds when the reservation is valid and its word matches. Address bits [1:0] take no part in the match. On success the store is forwarded, and the response on the memory acknowledge carries all-zero data, so bit 0 is 0.
- R5: A failing store-conditional raises no downstream strobe. The controller raises `rsp_ack` for exactly one cycle, in the cycle after the strobe, with data 1 (bit 0 = 1, all other bits 0). Memory is left unchanged.
- R6: Every store-conditional clears the reservation, whether it passes or fails.
- R7: A new load-reserved replaces any earlier reservation.
- R8: A strobed CPU write without `req_rvso` to the reserved word invalidates the reservation. A write to a different word leaves it intact.
- R9: A snoop write (`snp_stb`) to the reserved word invalidates the reservation. A snoop write to the reserved word in the same cycle as a store-conditional makes that store fail. A snoop write to the same word as a load-reserved in the same cycle leaves no reservation.
- R10: Reads, instruction fetches, privileged accesses and fence indications never change the reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_stb | input | 1 | CPU request strobe |
| req_addr | input | AW | CPU byte address |
| req_wdata | input | DW | CPU write data |
| req_we | input | 1 | 1 = write, 0 = read |
| req_src | input | 1 | 0 = instruction fetch, 1 = load/store |
| req_priv | input | 1 | Privileged access |
| req_rvso | input | 1 | Reservation operation (load-reserved / store-conditional) |
| req_fence | input | 1 | Fence indication, valid without strobe |
| snp_stb | input | 1 | Write by another bus master |
| snp_addr | input | AW | Byte address of that write |
| mem_stb | output | 1 | Downstream strobe |
| mem_addr | output | AW | Downstream address |
| mem_wdata | output | DW | Downstream write data |
| mem_we | output | 1 | Downstream write flag |
| mem_src | output | 1 | Downstream source flag |
| mem_priv | output | 1 | Downstream privilege flag |
| mem_fence | output | 1 | Downstream fence indication |
| mem_rdata | input | DW | Downstream read data |
| mem_ack | input | 1 | Downstream acknowledge |
| rsp_rdata | output | DW | Response data to the CPU |
| rsp_ack | output | 1 | Response acknowledge to the CPU |

## Verification
The store-conditional is tried in several situations. With no reservation at all it shows that the reset state is empty. Just after a successful pair it shows that a store-conditional clears the entry. It is also tried after a second load-reserved to another word, and to a neighbouring word. A byte offset inside the reserved word shows that the low address bits are ignored. Plain writes go to the reserved word and to the next word, which separates a word-exact match from a coarser one. Snoop writes come both in separate cycles and in the same cycle as the load-reserved or the store-conditional. Fetches, privileged reads and fences placed between a pair must leave the pair working.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   // request attributes carried next to the address
   typedef struct packed {
      logic we;
      logic src;
      logic priv;
      logic fence;
   } rsc_attr_t;

   // what a strobed request means to the reservation entry
   typedef enum logic [1:0] {
      RSC_PLAIN = 2'd0,
      RSC_LR    = 2'd1,
      RSC_SC    = 2'd2
   } rsc_kind_e;

   function automatic rsc_kind_e rsc_classify(input logic rvso, input logic we);
      if (!rvso)   return RSC_PLAIN;
      else if (we) return RSC_SC;
      else         return RSC_LR;
   endfunction

endpackage

// File: rtl/rsc_resv_entry.sv
module rsc_resv_entry #(
   parameter int AW   = 32,
   parameter int LSB  = 2,
   parameter int NCMP = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_i,
   input  logic [AW-1:0]            set_addr_i,
   input  logic                     kill_i,
   input  logic [NCMP-1:0][AW-1:0]  cmp_addr_i,
   output logic                     valid_o,
   output logic [NCMP-1:0]          hit_o
);
   localparam int TW = AW - LSB;

   logic          valid_q;
   logic [TW-1:0] tag_q;

   // a fresh reservation wins over a kill of the old one
   always_ff @(posedge clk) begin
      if (!rst_n)      valid_q <= 1'b0;
      else if (set_i)  valid_q <= 1'b1;
      else if (kill_i) valid_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (set_i) tag_q <= set_addr_i[AW-1:LSB];
   end

   for (genvar g = 0; g < NCMP; g++) begin : g_cmp
      assign hit_o[g] = valid_q && (cmp_addr_i[g][AW-1:LSB] == tag_q);
   end

   assign valid_o = valid_q;
endmodule

// File: rtl/rsc_sc_gate.sv
module rsc_sc_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   input  logic is_sc_i,
   input  logic sc_ok_i,
   input  logic mem_ack_i,
   output logic fwd_stb_o,
   output logic fail_q_o,
   output logic pend_q_o
);
   logic fail_now;

   assign fail_now  = stb_i && is_sc_i && !sc_ok_i;
   assign fwd_stb_o = stb_i && !fail_now;

   // local one-cycle answer for a blocked store-conditional
   always_ff @(posedge clk) begin
      if (!rst_n) fail_q_o <= 1'b0;
      else        fail_q_o <= fail_now;
   end

   // a forwarded store-conditional waits for the memory acknowledge
   always_ff @(posedge clk) begin
      if (!rst_n)                               pend_q_o <= 1'b0;
      else if (stb_i && is_sc_i && sc_ok_i)     pend_q_o <= 1'b1;
      else if (mem_ack_i)                       pend_q_o <= 1'b0;
   end
endmodule

// File: rtl/rsc_rsp_build.sv
module rsc_rsp_build #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ack_i,
   input  logic          fail_q_i,
   input  logic          pend_q_i,
   output logic [DW-1:0] rsp_rdata_o,
   output logic          rsp_ack_o
);
   localparam logic [DW-1:0] FAIL_WORD = DW'(1);

   always_comb begin
      if (fail_q_i)      rsp_rdata_o = FAIL_WORD;
      else if (pend_q_i) rsp_rdata_o = '0;
      else               rsp_rdata_o = mem_rdata_i;
   end

   assign rsp_ack_o = mem_ack_i || fail_q_i;
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_stb,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          req_we,
   input  logic          req_src,
   input  logic          req_priv,
   input  logic          req_rvso,
   input  logic          req_fence,
   input  logic          snp_stb,
   input  logic [AW-1:0] snp_addr,
   output logic          mem_stb,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic          mem_src,
   output logic          mem_priv,
   output logic          mem_fence,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_ack
);
   import rsc_pkg::*;

   localparam int LSB  = $clog2(DW / 8);
   localparam int NCMP = 2;

   if (DW < 16 || (DW % 8) != 0 || (1 << LSB) * 8 != DW) begin : g_bad_dw
      $error("rsc_ctrl: DW must be a power-of-two number of bytes");
   end
   if (AW <= LSB) begin : g_bad_aw
      $error("rsc_ctrl: AW too small for word granule");
   end

   rsc_kind_e kind;
   rsc_attr_t attr;
   logic [NCMP-1:0]         hit;
   logic [NCMP-1:0][AW-1:0] cmp_addr;
   logic is_sc, is_lr, snp_kill, lr_snooped, sc_ok, set_res, kill_res;
   logic resv_valid, fail_q, pend_q, fwd_stb;

   assign kind     = rsc_classify(req_rvso, req_we);
   assign is_sc    = (kind == RSC_SC);
   assign is_lr    = (kind == RSC_LR);
   assign cmp_addr = {snp_addr, req_addr};

   assign snp_kill   = snp_stb && hit[1];
   assign lr_snooped = snp_stb && (snp_addr[AW-1:LSB] == req_addr[AW-1:LSB]);
   assign sc_ok      = is_sc && hit[0] && !snp_kill;
   assign set_res    = req_stb && is_lr && !lr_snooped;
   assign kill_res   = snp_kill || (req_stb && (is_sc || (req_we && hit[0])));

   rsc_resv_entry #(.AW(AW), .LSB(LSB), .NCMP(NCMP)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_res),
      .set_addr_i (req_addr),
      .kill_i     (kill_res),
      .cmp_addr_i (cmp_addr),
      .valid_o    (resv_valid),
      .hit_o      (hit)
   );

   rsc_sc_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_i     (req_stb),
      .is_sc_i   (is_sc),
      .sc_ok_i   (sc_ok),
      .mem_ack_i (mem_ack),
      .fwd_stb_o (fwd_stb),
      .fail_q_o  (fail_q),
      .pend_q_o  (pend_q)
   );

   rsc_rsp_build #(.DW(DW)) u_rsp (
      .mem_rdata_i (mem_rdata),
      .mem_ack_i   (mem_ack),
      .fail_q_i    (fail_q),
      .pend_q_i    (pend_q),
      .rsp_rdata_o (rsp_rdata),
      .rsp_ack_o   (rsp_ack)
   );

   assign attr      = '{we: req_we, src: req_src, priv: req_priv, fence: req_fence};
   assign mem_stb   = fwd_stb;
   assign mem_addr  = req_addr;
   assign mem_wdata = req_wdata;
   assign mem_we    = attr.we;
   assign mem_src   = attr.src;
   assign mem_priv  = attr.priv;
   assign mem_fence = attr.fence;

   logic unused_ok;
   assign unused_ok = resv_valid;
endmodule

// File: rtl/rsc_ctrl_chk.sv
module rsc_ctrl_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_stb,
   input logic          req_we,
   input logic          req_rvso,
   input logic          mem_stb,
   input logic          mem_ack,
   input logic          rsp_ack,
   input logic [DW-1:0] rsp_rdata
);
   logic sc_req, sc_fwd_q;
   assign sc_req = req_stb && req_rvso && req_we;

   always_ff @(posedge clk) begin
      if (!rst_n)                  sc_fwd_q <= 1'b0;
      else if (sc_req && mem_stb)  sc_fwd_q <= 1'b1;
      else if (mem_ack)            sc_fwd_q <= 1'b0;
   end

   p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) && sc_req |-> !mem_stb);

   p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_stb && !(req_rvso && req_we) |-> mem_stb);

   p_sc_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sc_fwd_q && mem_ack |-> rsp_rdata == '0);

   p_fail_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sc_req && !mem_stb |=> rsp_ack && rsp_rdata == DW'(1));

   p_sc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sc_req |=> !(sc_req && mem_stb));
endmodule

bind rsc_ctrl rsc_ctrl_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_stb   (req_stb),
   .req_we    (req_we),
   .req_rvso  (req_rvso),
   .mem_stb   (mem_stb),
   .mem_ack   (mem_ack),
   .rsp_ack   (rsp_ack),
   .rsp_rdata (rsp_rdata)
);

// File: tb/rsc_ctrl_test.sv
`timescale 1ns/1ps
module rsc_ctrl_test;
   localparam int AW = 32;
   localparam int DW = 32;
   // ops: 0 read, 1 write, 2 load-reserved, 3 store-conditional,
   //      4 snoop write, 5 privileged fetch read, 6 fence pulse
   localparam int NV = 37;
   // {op[3:0], addr[7:0], data[31:0], exp[31:0], tag[3:0]}
   localparam logic [79:0] VEC [NV] = '{
      {4'd1, 8'h10, 32'hAAAA0001, 32'h0,        4'd2},  // R2 write
      {4'd0, 8'h10, 32'h0,        32'hAAAA0001, 4'd2},  // R2 read back
      {4'd3, 8'h10, 32'h5,        32'h1,        4'd5},  // R5 no reservation
      {4'd0, 8'h10, 32'h0,        32'hAAAA0001, 4'd5},  // R5 memory kept
      {4'd2, 8'h10, 32'h0,        32'hAAAA0001, 4'd3},  // R3 LR returns data
      {4'd3, 8'h12, 32'h11,       32'h0,        4'd4},  // R4 offset ignored
      {4'd0, 8'h10, 32'h0,        32'h11,       4'd4},  // R4 written
      {4'd3, 8'h10, 32'h22,       32'h1,        4'd6},  // R6 cleared by pass
      {4'd0, 8'h10, 32'h0,        32'h11,       4'd6},
      {4'd2, 8'h10, 32'h0,        32'h11,       4'd7},  // R7
      {4'd2, 8'h20, 32'h0,        32'h0,        4'd7},  // R7 replace
      {4'd3, 8'h10, 32'h33,       32'h1,        4'd7},  // R7 old word lost
      {4'd2, 8'h20, 32'h0,        32'h0,        4'd5},
      {4'd3, 8'h24, 32'h44,       32'h1,        4'd5},  // R5 other word
      {4'd3, 8'h20, 32'h55,       32'h1,        4'd6},  // R6 cleared by fail
      {4'd2, 8'h20, 32'h0,        32'h0,        4'd8},
      {4'd1, 8'h20, 32'h66,       32'h0,        4'd8},  // R8 breaking write
      {4'd3, 8'h20, 32'h77,       32'h1,        4'd8},
      {4'd0, 8'h20, 32'h0,        32'h66,       4'd8},
      {4'd2, 8'h30, 32'h0,        32'h0,        4'd8},
      {4'd1, 8'h34, 32'h99,       32'h0,        4'd8},  // R8 other word
      {4'd3, 8'h30, 32'h88,       32'h0,        4'd8},
      {4'd0, 8'h30, 32'h0,        32'h88,       4'd8},
      {4'd2, 8'h30, 32'h0,        32'h88,       4'd9},
      {4'd4, 8'h30, 32'hE1,       32'h0,        4'd9},  // R9 snoop hit
      {4'd3, 8'h30, 32'hF0,       32'h1,        4'd9},
      {4'd0, 8'h30, 32'h0,        32'hE1,       4'd9},
      {4'd2, 8'h30, 32'h0,        32'hE1,       4'd9},
      {4'd4, 8'h38, 32'hE2,       32'h0,        4'd9},  // R9 snoop miss
      {4'd3, 8'h30, 32'hF3,       32'h0,        4'd9},
      {4'd2, 8'h40, 32'h0,        32'h0,        4'd10}, // R10
      {4'd5, 8'h40, 32'h0,        32'h0,        4'd10}, // R10 fetch
      {4'd6, 8'h00, 32'h0,        32'h0,        4'd10}, // R10 fence
      {4'd3, 8'h40, 32'hAB,       32'h0,        4'd10},
      {4'd0, 8'h40, 32'h0,        32'hAB,       4'd10},
      {4'd0, 8'h34, 32'h0,        32'h99,       4'd2},
      {4'd0, 8'h38, 32'h0,        32'hE2,       4'd9}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_stb = 0, req_we = 0, req_src = 1, req_priv = 0, req_rvso = 0, req_fence = 0;
   logic [AW-1:0] req_addr = '0, snp_addr = '0;
   logic [DW-1:0] req_wdata = '0, snp_data = '0;
   logic          snp_stb = 0;
   logic          mem_stb, mem_we, mem_src, mem_priv, mem_fence, rsp_ack;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, rsp_rdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem [32];
   int nvec = 0, nfail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rsc_ctrl #(.AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_we(req_we), .req_src(req_src), .req_priv(req_priv),
      .req_rvso(req_rvso), .req_fence(req_fence), .snp_stb(snp_stb), .snp_addr(snp_addr),
      .mem_stb(mem_stb), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_src(mem_src), .mem_priv(mem_priv), .mem_fence(mem_fence),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack));

   // memory with one cycle of latency, plus the other master's writes
   initial for (int i = 0; i < 32; i++) mem[i] = '0;
   always @(posedge clk) begin
      mem_ack <= mem_stb;
      if (mem_stb) mem_rdata <= mem[mem_addr[6:2]];
      if (mem_stb && mem_we) mem[mem_addr[6:2]] <= mem_wdata;
      if (snp_stb) mem[snp_addr[6:2]] <= snp_data;
   end

   task automatic check(input bit ok, input int tag, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   endtask

   task automatic do_op(input int op, input logic [31:0] addr, input logic [31:0] data,
                        input logic [31:0] exp, input int tag, input bit same_snp);
      int wd;
      @(negedge clk);
      if (op == 4) begin
         snp_stb = 1; snp_addr = addr; snp_data = data;
         @(negedge clk); snp_stb = 0;
         return;
      end
      if (op == 6) begin
         req_fence = 1; #0.5;
         check(mem_fence && !mem_stb, 2, {30'd0, mem_fence, mem_stb}, 32'h2, "fence without strobe");
         @(negedge clk); req_fence = 0;
         return;
      end
      req_addr = addr; req_wdata = data;
      req_we = (op == 1 || op == 3); req_rvso = (op == 2 || op == 3);
      req_src = (op != 5); req_priv = (op == 5); req_stb = 1;
      if (same_snp) begin snp_stb = 1; snp_addr = addr; snp_data = 32'hC0DE; end
      #0.5;
      if (op == 3)
         check(mem_stb == (exp == 0), tag, {31'd0, mem_stb}, {31'd0, exp == 0}, "sc downstream strobe");
      else
         check(mem_stb && mem_addr == addr && mem_we == req_we && mem_src == req_src,
               2, mem_addr, addr, "forwarded request");
      @(negedge clk);
      req_stb = 0; req_we = 0; req_rvso = 0; req_src = 1; req_priv = 0; snp_stb = 0;
      wd = 0;
      while (!rsp_ack && wd < 20) begin @(negedge clk); wd++; end
      check(rsp_ack && wd == 0, tag, {31'd0, rsp_ack}, 32'h1, "ack in cycle after strobe");
      if ((op == 0 || op == 3 || op == 5 || (op == 2 && !same_snp)))
         check(rsp_rdata == exp, tag, rsp_rdata, exp, "response data");
      if (op == 3 && exp != 0) begin
         @(negedge clk);
         check(!rsp_ack, 5, {31'd0, rsp_ack}, 32'h0, "fail ack one cycle only");
      end
   endtask

   initial begin
      #1000000;
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!rsp_ack && !mem_stb, 1, {30'd0, rsp_ack, mem_stb}, 32'h0, "outputs in reset");
      rst_n = 1;
      do_op(3, 32'h10, 32'h5, 32'h1, 1, 0);                 // R1 no reservation after reset
      for (int i = 0; i < NV; i++)
         do_op(int'(VEC[i][79:76]), {24'd0, VEC[i][75:68]}, VEC[i][67:36],
               VEC[i][35:4], int'(VEC[i][3:0]), 0);
      // R1 reset in the middle of a reservation
      do_op(2, 32'h70, 32'h0, 32'h0, 1, 0);
      @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
      do_op(3, 32'h70, 32'h71, 32'h1, 1, 0);
      // R9 snoop in the same cycle as the load-reserved
      do_op(2, 32'h50, 32'h0, 32'h0, 9, 1);
      do_op(3, 32'h50, 32'h51, 32'h1, 9, 0);
      // R9 snoop in the same cycle as the store-conditional
      do_op(2, 32'h60, 32'h0, 32'h0, 9, 0);
      do_op(3, 32'h60, 32'h61, 32'h1, 9, 1);
      do_op(0, 32'h60, 32'h0, 32'hC0DE, 9, 0);
      finish_run();
   end
endmodule